// File: doc/BRIEF.md
# Indexed Register Gather Sequencer

This block carries out a vector move in which the source of each element is chosen by register contents rather than by the instruction. When a start is accepted it latches three base register numbers (destination, index and source) and an element count. For each element e, counting upward from zero, it reads an index value from the register numbered index base + e. It checks that value against the element count. If the value is in range, it reads the register at source base + index and writes that value to destination base + e. Register numbers are five bits wide and wrap around the 32-entry file.

The register file sits outside the block. The sequencer drives one read port and one write port, and expects read data combinationally in the cycle it presents a read address. Each element passes through three phases: fetch index, fetch source, write. If an index value is equal to or larger than the element count, the operation stops with a trap pulse and reports the element that failed. While the operation runs, the block reports the span of source registers it may read, so that hazard logic elsewhere can hold off writers to that range.

Top module: `gather_unit`

## Requirements
- R1: Element e reads its index from register (idx_base+e) mod 32 and writes register (dst_base+e) mod 32 with the value of register (src_base+index) mod 32; elements run in ascending order, and each element observes the writes of the elements before it.
- R2: Each element takes exactly three cycles (index read, source read, write). The done output is high for exactly one cycle, following the 3·N-th rising edge after the edge that accepts start, where N is the element count.
- R3: The index value is compared as an unsigned 16-bit number. If element k reads an index equal to or larger than N, trap is high for one cycle following rising edge 3·k+1 after acceptance, element k and all later elements make no write, and done is not raised.
- R4: trap_elem holds the number of the failing element from the trap until the next accepted start, which clears it to zero.
- R5: An element count of zero raises done after the accepting edge and writes nothing.
- R6: Every register number (index, source, destination) wraps modulo 32.
- R7: busy is high from the accepting edge until the edge that raises done or trap. A start while busy is ignored and does not change the running operation.
- R8: While busy, dep_valid is 1, dep_base equals the source base, and dep_span is the smallest power of two that is at least N+1, capped at 32; these stay constant for the whole operation.
- R9: After reset, busy, done, trap, rf_re and rf_we are all low. A write is never issued in the same cycle as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| dst_base | input | 5 | First destination register |
| idx_base | input | 5 | First index register |
| src_base | input | 5 | Source base register |
| elem_cnt | input | 6 | Element count N (0 to 32) |
| busy | output | 1 | Operation in progress |
| rf_re | output | 1 | Read port enable |
| rf_raddr | output | 5 | Read port address |
| rf_rdata | input | 16 | Read port data, valid in the same cycle |
| rf_we | output | 1 | Write port enable |
| rf_waddr | output | 5 | Write port address |
| rf_wdata | output | 16 | Write port data |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | One-cycle out-of-range index pulse |
| trap_elem | output | 5 | Element that caused the last trap |
| dep_valid | output | 1 | Source dependency range is valid |
| dep_base | output | 5 | First register of the source range |
| dep_span | output | 6 | Power-of-two size of the source range |

## Verification
The bench covers an index exactly equal to N, which a wrong off-by-one compare would let through as a move, and an index with only its high bits set, which a design comparing just five bits would also miss. It runs base registers that wrap past register 31 and operations whose destination overlaps the index or source registers. If a design buffered its reads ahead of its writes, or wrapped register numbers wrongly, the final register file would differ from the sequential model. It also covers a trap on element zero (a design that wrote before checking would corrupt a register), a start raised mid-run (a design that re-accepts it would end early), a zero count (which would hang or write something), and the span cap at a count of 32.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_IDX  = 2'd1,
    PH_SRC  = 2'd2,
    PH_WR   = 2'd3
  } phase_e;
endpackage

// File: rtl/gather_span.sv
module gather_span #(
  parameter int NREG = 32,
  localparam int VL_W = $clog2(NREG) + 1
) (
  input  logic [VL_W-1:0] cnt,
  output logic [VL_W-1:0] span
);
  localparam int SW = VL_W + 1;
  logic [SW-1:0] need;
  logic [SW-1:0] s;

  always_comb begin
    need = SW'(cnt) + SW'(1);
    s = SW'(1);
    for (int k = 0; k < SW; k++) begin
      if (s < need) s = s << 1;
    end
    if (s > SW'(NREG)) s = SW'(NREG);
    span = s[VL_W-1:0];
  end
endmodule

// File: rtl/gather_fsm.sv
module gather_fsm
  import gather_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  cnt_in,
  input  logic [VL_W-1:0]  cnt_q,
  input  logic             idx_bad,
  output phase_e           ph,
  output logic [IDX_W-1:0] elem,
  output logic             accept,
  output logic             done,
  output logic             trap,
  output logic [IDX_W-1:0] trap_elem
);
  phase_e           ph_n;
  logic [IDX_W-1:0] elem_n;
  logic             elem_en;
  logic             done_n;
  logic             trap_n;
  logic [IDX_W-1:0] te_n;
  logic             te_en;
  logic             last;

  assign accept = (ph == PH_IDLE) && start;
  assign last   = (VL_W'(elem) == (cnt_q - VL_W'(1)));

  always_comb begin
    ph_n    = ph;
    elem_n  = elem;
    elem_en = 1'b0;
    done_n  = 1'b0;
    trap_n  = 1'b0;
    te_n    = trap_elem;
    te_en   = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        if (start) begin
          te_n  = '0;
          te_en = 1'b1;
          if (cnt_in == '0) begin
            done_n = 1'b1;
          end else begin
            ph_n    = PH_IDX;
            elem_n  = '0;
            elem_en = 1'b1;
          end
        end
      end
      PH_IDX: begin
        if (idx_bad) begin
          trap_n = 1'b1;
          te_n   = elem;
          te_en  = 1'b1;
          ph_n   = PH_IDLE;
        end else begin
          ph_n = PH_SRC;
        end
      end
      PH_SRC: ph_n = PH_WR;
      PH_WR: begin
        if (last) begin
          done_n = 1'b1;
          ph_n   = PH_IDLE;
        end else begin
          elem_n  = elem + IDX_W'(1);
          elem_en = 1'b1;
          ph_n    = PH_IDX;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      elem      <= '0;
      done      <= 1'b0;
      trap      <= 1'b0;
      trap_elem <= '0;
    end else begin
      ph   <= ph_n;
      done <= done_n;
      trap <= trap_n;
      if (elem_en) elem <= elem_n;
      if (te_en) trap_elem <= te_n;
    end
  end
endmodule

// File: rtl/gather_dp.sv
module gather_dp
  import gather_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  phase_e            ph,
  input  logic [IDX_W-1:0]  elem,
  input  logic [IDX_W-1:0]  dst_in,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [IDX_W-1:0]  src_in,
  input  logic [VL_W-1:0]   cnt_in,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [VL_W-1:0]   cnt_q,
  output logic [IDX_W-1:0]  src_q,
  output logic              idx_bad,
  output logic              rf_re,
  output logic [IDX_W-1:0]  rf_raddr,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  logic [IDX_W-1:0]  dst_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  ofs_q;
  logic [DATA_W-1:0] val_q;
  logic              ofs_en;
  logic              val_en;

  assign ofs_en  = (ph == PH_IDX);
  assign val_en  = (ph == PH_SRC);
  assign idx_bad = (ph == PH_IDX) && (rf_rdata >= DATA_W'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      idx_q <= '0;
      src_q <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      dst_q <= dst_in;
      idx_q <= idx_in;
      src_q <= src_in;
      cnt_q <= cnt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      val_q <= '0;
    end else begin
      if (ofs_en) ofs_q <= rf_rdata[IDX_W-1:0];
      if (val_en) val_q <= rf_rdata;
    end
  end

  always_comb begin
    rf_re    = (ph == PH_IDX) || (ph == PH_SRC);
    rf_raddr = (ph == PH_IDX) ? (idx_q + elem) : (src_q + ofs_q);
    rf_we    = (ph == PH_WR);
    rf_waddr = dst_q + elem;
    rf_wdata = val_q;
  end
endmodule

// File: rtl/gather_unit.sv
module gather_unit
  import gather_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  dst_base,
  input  logic [IDX_W-1:0]  idx_base,
  input  logic [IDX_W-1:0]  src_base,
  input  logic [VL_W-1:0]   elem_cnt,
  output logic              busy,
  output logic              rf_re,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              done,
  output logic              trap,
  output logic [IDX_W-1:0]  trap_elem,
  output logic              dep_valid,
  output logic [IDX_W-1:0]  dep_base,
  output logic [VL_W-1:0]   dep_span
);
  phase_e           ph;
  logic [IDX_W-1:0] elem;
  logic             accept;
  logic [VL_W-1:0]  cnt_q;
  logic [IDX_W-1:0] src_q;
  logic             idx_bad;

  gather_fsm #(.NREG(NREG)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(elem_cnt),
    .cnt_q(cnt_q), .idx_bad(idx_bad), .ph(ph), .elem(elem),
    .accept(accept), .done(done), .trap(trap), .trap_elem(trap_elem)
  );

  gather_dp #(.NREG(NREG), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ph(ph), .elem(elem),
    .dst_in(dst_base), .idx_in(idx_base), .src_in(src_base),
    .cnt_in(elem_cnt), .rf_rdata(rf_rdata), .cnt_q(cnt_q),
    .src_q(src_q), .idx_bad(idx_bad), .rf_re(rf_re),
    .rf_raddr(rf_raddr), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata)
  );

  gather_span #(.NREG(NREG)) u_span (
    .cnt(cnt_q), .span(dep_span)
  );

  assign busy      = (ph != PH_IDLE);
  assign dep_valid = busy;
  assign dep_base  = src_q;
endmodule

// File: rtl/gather_unit_chk.sv
module gather_unit_chk #(
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             trap,
  input logic [IDX_W-1:0] trap_elem,
  input logic             rf_we,
  input logic             rf_re,
  input logic             dep_valid,
  input logic [IDX_W-1:0] dep_base,
  input logic [VL_W-1:0]  dep_span
);
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && trap)); // R3
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy); // R2
  AST_NO_RW: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re)); // R9
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || trap)); // R7
  AST_TELEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(trap_elem)); // R4
  AST_DEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(dep_base) && $stable(dep_span))); // R8
  AST_SPAN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    dep_valid |-> ($countones(dep_span) == 1)); // R8
endmodule

bind gather_unit gather_unit_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .trap(trap), .trap_elem(trap_elem), .rf_we(rf_we), .rf_re(rf_re),
  .dep_valid(dep_valid), .dep_base(dep_base), .dep_span(dep_span)
);

// File: tb/tb_gather_unit.sv
module tb_gather_unit;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [4:0]  dst_base, idx_base, src_base;
  logic [5:0]  elem_cnt;
  logic        busy, rf_re, rf_we, done, trap, dep_valid;
  logic [4:0]  rf_raddr, rf_waddr, trap_elem, dep_base;
  logic [15:0] rf_rdata, rf_wdata;
  logic [5:0]  dep_span;

  logic [15:0] mem [32];
  logic [15:0] exp_mem [32];
  int n_chk = 0;
  int n_bad = 0;

  gather_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_base(dst_base),
    .idx_base(idx_base), .src_base(src_base), .elem_cnt(elem_cnt),
    .busy(busy), .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .done(done),
    .trap(trap), .trap_elem(trap_elem), .dep_valid(dep_valid),
    .dep_base(dep_base), .dep_span(dep_span)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign rf_rdata = mem[rf_raddr];
  always @(posedge clk) if (rf_we) mem[rf_waddr] <= rf_wdata;

  typedef struct packed {
    logic [4:0]  dst;
    logic [4:0]  idx;
    logic [4:0]  src;
    logic [5:0]  cnt;
    logic [4:0]  step;
    logic [4:0]  add;
    logic [5:0]  bad_at;
    logic [15:0] bad_val;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{5'd8,  5'd0,  5'd16, 6'd4,  5'd1, 5'd0, 6'd63, 16'h0},
    '{5'd20, 5'd2,  5'd10, 6'd5,  5'd3, 5'd1, 6'd63, 16'h0},
    '{5'd30, 5'd26, 5'd28, 6'd4,  5'd1, 5'd2, 6'd63, 16'h0},
    '{5'd12, 5'd4,  5'd0,  6'd6,  5'd1, 5'd0, 6'd2,  16'd6},
    '{5'd20, 5'd0,  5'd5,  6'd3,  5'd1, 5'd0, 6'd0,  16'hFF00},
    '{5'd5,  5'd5,  5'd9,  6'd1,  5'd0, 5'd0, 6'd63, 16'h0},
    '{5'd24, 5'd0,  5'd8,  6'd8,  5'd0, 5'd7, 6'd63, 16'h0},
    '{5'd0,  5'd0,  5'd0,  6'd32, 5'd5, 5'd3, 6'd63, 16'h0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int span_of(input int n);
    int s = 1;
    while (s < n + 1 && s < 32) s = s * 2;
    return s;
  endfunction

  task automatic fill_mem(input vec_t v);
    for (int j = 0; j < 32; j++) mem[j] = 16'hC000 ^ 16'(j * 16'h0111);
    for (int i = 0; i < int'(v.cnt); i++)
      mem[5'(v.idx + 5'(i))] = 16'((i * int'(v.step) + int'(v.add)) % int'(v.cnt));
    if (int'(v.bad_at) < int'(v.cnt)) mem[5'(v.idx + v.bad_at[4:0])] = v.bad_val;
  endtask

  // Sequential reference: returns failing element or -1.
  function automatic int model(input logic [4:0] d, input logic [4:0] x,
                               input logic [4:0] s, input int n);
    for (int j = 0; j < 32; j++) exp_mem[j] = mem[j];
    for (int i = 0; i < n; i++) begin
      logic [15:0] o;
      o = exp_mem[5'(x + 5'(i))];
      if (o >= 16'(n)) return i;
      exp_mem[5'(d + 5'(i))] = exp_mem[5'(s + o[4:0])];
    end
    return -1;
  endfunction

  task automatic cmp_mem(input string req);
    int diff = 0;
    for (int j = 0; j < 32; j++) if (mem[j] !== exp_mem[j]) diff++;
    chk(diff == 0, req, "regfile mismatching entries", diff, 0);
  endtask

  // Runs one operation; mid_start pulses start two cycles in (must be ignored).
  task automatic run_op(input logic [4:0] d, input logic [4:0] x,
                        input logic [4:0] s, input int n, input bit mid_start);
    int ek, cyc;
    ek = model(d, x, s, n);
    @(negedge clk);
    start = 1'b1; dst_base = d; idx_base = x; src_base = s; elem_cnt = 6'(n);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    if (n > 0) begin
      chk(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
      chk(dep_valid && dep_base == s, "R8", "dep_base", int'(dep_base), int'(s));
      chk(int'(dep_span) == span_of(n), "R8", "dep_span", int'(dep_span), span_of(n));
    end
    while (!done && !trap && cyc < 200) begin
      if (mid_start && cyc == 2) begin
        start = 1'b1; dst_base = 5'd1; idx_base = 5'd2; src_base = 5'd3; elem_cnt = 6'd0;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (ek < 0) begin
      chk(done && !trap, "R2", "done without trap", int'(trap), 0);
      chk(cyc == 3 * n, "R2", "done latency", cyc, 3 * n);
    end else begin
      chk(trap && !done, "R3", "trap without done", int'(done), 0);
      chk(cyc == 3 * ek + 1, "R3", "trap latency", cyc, 3 * ek + 1);
      chk(int'(trap_elem) == ek, "R4", "trap_elem", int'(trap_elem), ek);
    end
    @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !trap, "R7", "idle after end", int'(busy), 0);
    cmp_mem("R1");
  endtask

  initial begin
    int unsigned wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected 0", wd);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    dst_base = '0; idx_base = '0; src_base = '0; elem_cnt = '0;
    for (int j = 0; j < 32; j++) mem[j] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(!busy && !done && !trap && !rf_we && !rf_re, "R9", "outputs in reset",
        int'({busy, done, trap, rf_we, rf_re}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rf_we && !rf_re, "R9", "idle after reset", int'({busy, rf_we, rf_re}), 0);

    // Table walk: R1 R2 R3 R6 R8 (wrap, overlap, boundary index, high bits)
    for (int v = 0; v < NV; v++) begin
      fill_mem(TBL[v]);
      run_op(TBL[v].dst, TBL[v].idx, TBL[v].src, int'(TBL[v].cnt), 1'b0);
    end

    // R4: trap_elem held while idle after a trap on element 2
    fill_mem(TBL[3]);
    run_op(TBL[3].dst, TBL[3].idx, TBL[3].src, int'(TBL[3].cnt), 1'b0);
    repeat (4) @(negedge clk);
    chk(trap_elem == 5'd2 && !trap, "R4", "trap_elem hold", int'(trap_elem), 2);

    // R5: zero count completes at once and writes nothing; clears trap_elem
    fill_mem(TBL[0]);
    run_op(5'd3, 5'd4, 5'd5, 0, 1'b0);
    chk(trap_elem == 5'd0, "R4", "trap_elem cleared by start", int'(trap_elem), 0);
    chk(!busy, "R5", "no busy for zero count", int'(busy), 0);

    // R7: start while busy is ignored
    fill_mem(TBL[1]);
    run_op(TBL[1].dst, TBL[1].idx, TBL[1].src, int'(TBL[1].cnt), 1'b1);

    // R6: full wrap with dst at 31
    fill_mem(TBL[2]);
    run_op(5'd31, 5'd27, 5'd29, 4, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule